// File: doc/BRIEF.md
# Fan PWM Generator with Mode-Selected Period

This block produces the drive signal for one cooling fan. Software programs it through a small word-addressed register interface with single-cycle write and read strobes. One control word holds the run bit, the fan wiring mode and an 8-bit duty code. A second word holds a 16-bit maximum-speed value that is stored and read back for use by fan-management software. The PWM period is not programmable: it is fixed by the wiring mode. The 2/3-wire mode uses a long period, nominally 40 ms. The 4-wire mode uses a short period, nominally 40 us. Both are converted to clock cycles from parameters.

The duty code scales so that 0 keeps the output low and 255 keeps it high for the whole period. Codes between the two give floor(code x period_cycles / 255) high cycles at the start of every period. A new duty code or mode written while running is held in the control word and only adopted at the next period boundary, so the period in progress is never mixed. Clearing the run bit drives the output low and discards the period position. Setting it again starts a fresh period.

Top module: `fanpwm_ctrl`

## Requirements
- R1: Control word A is at address 0x0. Bit 0 is run (1 = active), bit 1 is mode (0 = long period, 1 = short period), and bits 23:16 are the duty code. All other bits read as 0. A read of any address other than 0x0 or 0x4 returns 0.
- R2: Control word B is at address 0x4. Bits 15:0 hold the maximum-speed value and read back as written; bits 31:16 read as 0. After reset, word B reads 4000 (0x00000FA0), word A reads 0 and the output is low.
- R3: With mode 0 the output repeats every LONG_NS x CLK_HZ / 1e9 clock cycles. With mode 1 it repeats every SHORT_NS x CLK_HZ / 1e9 cycles.
- R4: Each period starts with exactly floor(duty x P / 255) high cycles, where P is that period's length in cycles, followed by low for the rest of the period.
- R5: Duty code 0 keeps the output low for the whole period. Duty code 255 keeps it high for the whole period.
- R6: The output falls to 0 within two clock edges after a write that clears run, and stays 0 while run is 0. A write that sets run (with or without a duty change in the same write) starts a new period whose first output cycle is high for a nonzero duty, on the second clock edge after the write.
- R7: A duty code written while running leaves the period in progress unchanged. It governs every period from the next boundary on.
- R8: A mode change written while running takes effect at the next period boundary, where the counter restarts with the new period length.
- R9: rdata presents the addressed word on the clock edge after a cycle with rd_en high, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | ADDR_W | Byte address of the control word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pwm_out | output | 1 | Active-high fan drive |

## Verification
The assertions assume a synchronous reset pulse before any access. They also assume each period length parameter gives at least one cycle, so the counter bound and the boundary reload are well defined. The stimulus always issues strobes as one-cycle pulses driven between clock edges and never asserts write and read together. Long/short scaling is kept small through the period parameters, so full periods of both modes fit in the run while the cycle arithmetic stays the same as at the default rates.

// File: rtl/fanpwm_pkg.sv
package fanpwm_pkg;

    localparam int DUTY_W   = 8;
    localparam int SPEED_W  = 16;
    localparam int DUTY_FULL = 255;
    localparam logic [SPEED_W-1:0] SPEED_RST = 16'd4000;

    // Byte offsets of the two control words
    localparam logic [7:0] OFS_CTLA = 8'h00;
    localparam logic [7:0] OFS_CTLB = 8'h04;

    // Writable bits of each word; everything else is stored as zero
    localparam logic [31:0] CTLA_MASK = 32'h00FF_0003;
    localparam logic [31:0] CTLB_MASK = 32'h0000_FFFF;

    typedef enum logic {
        MODE_LONG  = 1'b0,
        MODE_SHORT = 1'b1
    } fan_mode_e;

    typedef struct packed {
        logic              run;
        fan_mode_e         mode;
        logic [DUTY_W-1:0] duty;
    } fan_cfg_t;

    function automatic longint unsigned cycles_of(longint unsigned hz,
                                                  longint unsigned ns);
        return (hz * ns) / 64'd1_000_000_000;
    endfunction

    function automatic fan_cfg_t cfg_from_word(logic [31:0] w);
        fan_cfg_t c;
        c.run  = w[0];
        c.mode = fan_mode_e'(w[1]);
        c.duty = w[23:16];
        return c;
    endfunction

endpackage

// File: rtl/fanpwm_regs.sv
module fanpwm_regs
    import fanpwm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output fan_cfg_t          cfg
);

    localparam logic [ADDR_W-1:0] A_CTLA = ADDR_W'(OFS_CTLA);
    localparam logic [ADDR_W-1:0] A_CTLB = ADDR_W'(OFS_CTLB);

    logic [31:0] ctla_q;
    logic [31:0] ctlb_q;
    logic [31:0] rd_mux;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctla_q <= '0;
            ctlb_q <= {{(32-SPEED_W){1'b0}}, SPEED_RST};
        end else if (wr_en) begin
            if (addr == A_CTLA) ctla_q <= wdata & CTLA_MASK;
            if (addr == A_CTLB) ctlb_q <= wdata & CTLB_MASK;
        end
    end

    always_comb begin
        if (addr == A_CTLA)      rd_mux = ctla_q;
        else if (addr == A_CTLB) rd_mux = ctlb_q;
        else                     rd_mux = '0;
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    assign cfg = cfg_from_word(ctla_q);

endmodule

// File: rtl/fanpwm_timebase.sv
module fanpwm_timebase
    import fanpwm_pkg::*;
#(
    parameter int              CNT_W     = 23,
    parameter longint unsigned LONG_CYC  = 8_000_000,
    parameter longint unsigned SHORT_CYC = 8_000
) (
    input  logic              clk,
    input  logic              rst,
    input  fan_cfg_t          cfg,
    output logic              armed,
    output logic              wrap,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  period_len,
    output logic [DUTY_W-1:0] act_duty
);

    localparam logic [CNT_W-1:0] LONG_LEN  = CNT_W'(LONG_CYC);
    localparam logic [CNT_W-1:0] SHORT_LEN = CNT_W'(SHORT_CYC);

    fan_mode_e act_mode;

    assign period_len = (act_mode == MODE_SHORT) ? SHORT_LEN : LONG_LEN;
    assign wrap       = cfg.run && armed && (cnt == period_len - CNT_W'(1));

    // Settings are copied from the control word only when a period begins:
    // on arming after run is set, and at every wrap.
    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            cnt      <= '0;
            act_duty <= '0;
            act_mode <= MODE_LONG;
        end else if (!cfg.run) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (!armed || wrap) begin
            armed    <= 1'b1;
            cnt      <= '0;
            act_duty <= cfg.duty;
            act_mode <= cfg.mode;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/fanpwm_compare.sv
module fanpwm_compare
    import fanpwm_pkg::*;
#(
    parameter int CNT_W = 23
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  period_len,
    input  logic [DUTY_W-1:0] duty,
    output logic              pwm_q
);

    localparam int PROD_W = CNT_W + DUTY_W + 1;

    logic [PROD_W-1:0] lhs;
    logic [PROD_W-1:0] rhs;
    logic              hit;

    // cnt < floor(duty*P/255)  <=>  255*(cnt+1) <= duty*P
    assign lhs = (PROD_W'(cnt) + PROD_W'(1)) * PROD_W'(DUTY_FULL);
    assign rhs = PROD_W'(duty) * PROD_W'(period_len);
    assign hit = (lhs <= rhs);

    always_ff @(posedge clk) begin
        if (rst) pwm_q <= 1'b0;
        else     pwm_q <= active && hit;
    end

endmodule

// File: rtl/fanpwm_ctrl.sv
module fanpwm_ctrl
    import fanpwm_pkg::*;
#(
    parameter longint unsigned CLK_HZ   = 200_000_000,
    parameter longint unsigned LONG_NS  = 40_000_000,
    parameter longint unsigned SHORT_NS = 40_000,
    parameter int              ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              pwm_out
);

    localparam longint unsigned LONG_CYC  = cycles_of(CLK_HZ, LONG_NS);
    localparam longint unsigned SHORT_CYC = cycles_of(CLK_HZ, SHORT_NS);
    localparam longint unsigned MAX_CYC   = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int              CNT_W     = $clog2(MAX_CYC + 1);

    fan_cfg_t          cfg;
    logic              cfg_run;
    logic              armed;
    logic              wrap;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  period_len;
    logic [DUTY_W-1:0] act_duty;

    assign cfg_run = cfg.run;

    fanpwm_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .cfg   (cfg)
    );

    fanpwm_timebase #(
        .CNT_W     (CNT_W),
        .LONG_CYC  (LONG_CYC),
        .SHORT_CYC (SHORT_CYC)
    ) u_tb (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .armed      (armed),
        .wrap       (wrap),
        .cnt        (cnt),
        .period_len (period_len),
        .act_duty   (act_duty)
    );

    fanpwm_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk        (clk),
        .rst        (rst),
        .active     (cfg_run && armed),
        .cnt        (cnt),
        .period_len (period_len),
        .duty       (act_duty),
        .pwm_q      (pwm_out)
    );

endmodule

// File: rtl/fanpwm_ctrl_chk.sv
module fanpwm_ctrl_chk #(
    parameter int CNT_W = 23
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_run,
    input logic             armed,
    input logic             wrap,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] period_len,
    input logic [7:0]       act_duty,
    input logic             pwm_out
);

    p_cnt_in_period_r3: assert property (@(posedge clk) disable iff (rst)
        armed |-> (cnt < period_len));

    p_full_high_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_run && armed && act_duty == 8'd255) |=> pwm_out);

    p_zero_low_r5: assert property (@(posedge clk) disable iff (rst)
        (act_duty == 8'd0) |=> !pwm_out);

    p_off_low_r6: assert property (@(posedge clk) disable iff (rst)
        !cfg_run |=> !pwm_out);

    p_fresh_start_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> (cnt == '0 && !pwm_out));

    p_hold_duty_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_run && armed && !wrap) |=> $stable(act_duty));

    p_wrap_restart_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_run && wrap) |=> (cnt == '0));

endmodule

bind fanpwm_ctrl fanpwm_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_run    (cfg_run),
    .armed      (armed),
    .wrap       (wrap),
    .cnt        (cnt),
    .period_len (period_len),
    .act_duty   (act_duty),
    .pwm_out    (pwm_out)
);

// File: tb/fanpwm_ctrl_bench.sv
`timescale 1ns/1ps
module fanpwm_ctrl_bench;

    localparam int PL = 1200;  // long period in cycles at the bench scale
    localparam int PS = 500;   // short period in cycles

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        pwm_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    fanpwm_ctrl #(
        .CLK_HZ   (200_000_000),
        .LONG_NS  (6_000),
        .SHORT_NS (2_500),
        .ADDR_W   (4)
    ) u_fanpwm_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .pwm_out (pwm_out)
    );

    // {mode, duty}
    localparam logic [8:0] VEC [0:8] = '{
        9'h100, 9'h101, 9'h180, 9'h1FE, 9'h1FF,
        9'h003, 9'h064, 9'h0FF, 9'h000
    };

    function automatic int hi_cycles(int duty, int p);
        return (duty * p) / 255;
    endfunction

    function automatic logic [31:0] ctla(bit run, bit mode, int duty);
        return {8'h00, 8'(duty), 14'h0, mode, run};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic measure(int len, output int hc, output bit first_hi);
        hc = 0;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            if (k == 0) first_hi = pwm_out;
            if (pwm_out) hc++;
        end
    endtask

    task automatic rise_gap(output int gap);
        logic prev;
        int   n;
        prev = pwm_out;
        n = 0;
        while (!(pwm_out && !prev) && n < 5000) begin
            prev = pwm_out; @(negedge clk); n++;
        end
        gap = 0;
        prev = pwm_out;
        while (gap < 5000) begin
            @(negedge clk); gap++;
            if (pwm_out && !prev) break;
            prev = pwm_out;
        end
    endtask

    initial begin
        #(500_000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int hc, gap;
        bit fh;

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R2: reset state
        check(pwm_out == 1'b0, "R2 reset output", pwm_out, 0);
        rd(4'h0, d); check(d == 32'h0, "R2 reset word A", d, 0);
        rd(4'h4, d); check(d == 32'h0000_0FA0, "R2 reset word B", d, 32'h0FA0);

        // R1/R2: field positions and reserved bits
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, d); check(d == 32'h00FF_0003, "R1 word A readback", d, 32'h00FF0003);
        wr(4'h0, 32'h0);
        wr(4'h4, 32'hFFFF_1234);
        rd(4'h4, d); check(d == 32'h0000_1234, "R2 word B readback", d, 32'h1234);
        rd(4'h8, d); check(d == 32'h0, "R1 unmapped read", d, 0);

        // R9: rdata holds between reads
        repeat (3) @(negedge clk);
        check(rdata == 32'h0 && d == 32'h0, "R9 rdata hold", rdata, 0);
        rd(4'h4, d);
        check(d == 32'h0000_1234, "R9 read latency", d, 32'h1234);

        // R4/R5: table of mode/duty vectors, one full first period each
        for (int i = 0; i < 9; i++) begin
            int  duty = int'(VEC[i][7:0]);
            bit  md   = VEC[i][8];
            int  p    = md ? PS : PL;
            wr(4'h0, 32'h0);
            wr(4'h0, ctla(1'b1, md, duty));
            @(negedge clk);
            measure(p, hc, fh);
            if (duty == 0 || duty == 255)
                check(hc == hi_cycles(duty, p), "R5 end code high count", hc, hi_cycles(duty, p));
            else
                check(hc == hi_cycles(duty, p), "R4 high count", hc, hi_cycles(duty, p));
        end

        // R3: period length in both modes
        wr(4'h0, 32'h0);
        wr(4'h0, ctla(1'b1, 1'b1, 128));
        rise_gap(gap); check(gap == PS, "R3 short period", gap, PS);
        wr(4'h0, 32'h0);
        wr(4'h0, ctla(1'b1, 1'b0, 128));
        rise_gap(gap); check(gap == PL, "R3 long period", gap, PL);

        // R6: disable forces low, re-enable starts a fresh period
        wr(4'h0, 32'h0);
        wr(4'h0, ctla(1'b1, 1'b1, 255));
        repeat (37) @(negedge clk);
        wr(4'h0, ctla(1'b0, 1'b1, 255));
        @(negedge clk);
        measure(40, hc, fh);
        check(hc == 0, "R6 low while disabled", hc, 0);
        wr(4'h0, ctla(1'b1, 1'b1, 60));
        @(negedge clk);
        measure(PS, hc, fh);
        check(fh == 1'b1, "R6 first cycle high", fh, 1);
        check(hc == hi_cycles(60, PS), "R6 fresh period count", hc, hi_cycles(60, PS));

        // R7: duty change while running
        wr(4'h0, 32'h0);
        wr(4'h0, ctla(1'b1, 1'b1, 200));
        @(negedge clk);
        fork
            measure(PS, hc, fh);
            begin repeat (100) @(negedge clk); wr(4'h0, ctla(1'b1, 1'b1, 20)); end
        join
        check(hc == hi_cycles(200, PS), "R7 current period kept", hc, hi_cycles(200, PS));
        measure(PS, hc, fh);
        check(hc == hi_cycles(20, PS), "R7 next period new duty", hc, hi_cycles(20, PS));

        // R8: mode change while running
        wr(4'h0, 32'h0);
        wr(4'h0, ctla(1'b1, 1'b0, 77));
        @(negedge clk);
        fork
            measure(PL, hc, fh);
            begin repeat (100) @(negedge clk); wr(4'h0, ctla(1'b1, 1'b1, 77)); end
        join
        check(hc == hi_cycles(77, PL), "R8 long period kept", hc, hi_cycles(77, PL));
        measure(PS, hc, fh);
        check(hc == hi_cycles(77, PS), "R8 short after boundary", hc, hi_cycles(77, PS));
        measure(PS, hc, fh);
        check(hc == hi_cycles(77, PS), "R8 short period repeats", hc, hi_cycles(77, PS));

        wr(4'h0, 32'h0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule